// File: doc/BRIEF.md
# Glitch-Tolerant Two-of-Seven Link Transmitter

This block takes packets from the on-chip network and sends them over a chip-to-chip link. On the on-chip side, each 4-bit flit arrives as a three-hot pattern on six data wires. An end-of-packet marker arrives on its own single wire. Both use a four-phase, return-to-zero handshake. On the link side, every symbol is sent as a transition on exactly two of seven wires, which is a two-phase, non-return-to-zero scheme. The end-of-packet marker becomes its own symbol in the same wire stream, placed after the data of its packet.

The data path is a short pipeline. An input stage checks the three-hot code and runs the four-phase handshake. A one-entry holding slot sits between the input stage and the line encoder. The line encoder toggles the link wires and then waits for the far end to acknowledge. The returning acknowledge is a single wire that the far end flips once per symbol. A transition detector turns each flip, in either direction, into one internal event. An event that arrives while no symbol is outstanding is thrown away. This can happen after this block is reset while the far end is not, or after a glitch on the acknowledge wire. Discarding such an event neither credits a later symbol nor stalls the link. Each wire is modelled as a register bit sampled on the clock.

Top module: `glx_link_tx`

## Requirements
- R1: While and after reset, `in_ack` is 0 and all seven `link_out` wires are 0.
- R2: With `in_eop` low, an `in_data` pattern with exactly three ones is taken as a flit when it is among the 16 lowest-valued such patterns. The flit value is the pattern's position in ascending numeric order (7 → 0, 11 → 1, …, 44 → 15). Acceptance is shown by `in_ack` rising.
- R3: The block ignores, with `in_ack` staying 0 and no link activity, every other input: any pattern without exactly three ones, the four high three-hot patterns (49, 50, 52, 56), and `in_eop` high together with nonzero `in_data`.
- R4: `in_eop` high with `in_data` all zero is accepted as an end-of-packet marker.
- R5: Once raised, `in_ack` stays high until `in_data` is all zero and `in_eop` is low, and then it falls.
- R6: Each symbol flips exactly two `link_out` bits. The pair flipped for flit n is the n-th value, counting from 0, among 7-bit values with two ones in ascending order (flit 0 → 0000011, flit 15 → 1000001). The end-of-packet symbol is entry 16 (1000010).
- R7: Symbols leave on the link in the same order in which their flits and markers were accepted.
- R8: After a symbol is sent, `link_out` does not change again until a transition on `link_ack` has been seen.
- R9: A rising or a falling transition of `link_ack` each count as one acknowledge.
- R10: A `link_ack` transition that arrives while no symbol is outstanding, including the first one after reset, is discarded. It does not pre-acknowledge the next symbol.
- R11: While one symbol awaits acknowledge, one more flit or marker can be accepted and held. A further one is not acknowledged until the link moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high, local to this block |
| in_data | input | 6 | Three-hot flit code, returns to zero between flits |
| in_eop | input | 1 | End-of-packet request, returns to zero |
| in_ack | output | 1 | Four-phase acknowledge to the on-chip side |
| link_out | output | 7 | Link wires, two toggle per symbol |
| link_ack | input | 1 | Two-phase acknowledge from the far end |

## Verification
All 16 flit codes and the end-of-packet marker are sent in both ascending and descending order. The received transition pairs are compared in sequence, which separates a wrong code table from a reordering of symbols. All 64 six-bit input patterns are swept, and the invalid ones must draw no acknowledge. This separates a popcount-only check from the full valid-code check. Withheld acknowledges expose the holding slot and the one-symbol-in-flight limit. Stray acknowledge flips, both just after reset and between packets, show whether a discarded event wrongly credits the next symbol.

// File: rtl/glx_pkg.sv
package glx_pkg;
  localparam int IW       = 6;   // on-chip data wires
  localparam int IHOT     = 3;   // ones per on-chip code
  localparam int OW       = 7;   // link wires
  localparam int OHOT     = 2;   // wires flipped per symbol
  localparam int NW       = 4;   // flit width
  localparam int EOP_RANK = 2 ** NW;
  localparam int SYMS     = EOP_RANK + 1;
  localparam int SW       = $clog2(SYMS);

  // position of an input code among all IHOT-hot codes, ascending
  function automatic int in_rank(input logic [IW-1:0] c);
    int n;
    n = 0;
    for (int v = 0; v < 2 ** IW; v++) begin
      if (v < int'(c) && $countones(v[IW-1:0]) == IHOT) n++;
    end
    return n;
  endfunction

  function automatic logic in_valid(input logic [IW-1:0] c);
    return ($countones(c) == IHOT) && (in_rank(c) < EOP_RANK);
  endfunction

  // r-th OHOT-hot link code in ascending numeric order
  function automatic logic [OW-1:0] out_code(input int r);
    logic [OW-1:0] res;
    int n;
    res = '0;
    n = 0;
    for (int v = 0; v < 2 ** OW; v++) begin
      if ($countones(v[OW-1:0]) == OHOT) begin
        if (n == r) res = v[OW-1:0];
        n++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/glx_fourph_in.sv
module glx_fourph_in
  import glx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] din,
  input  logic          eop_req,
  input  logic          slot_free,
  output logic          in_ack,
  output logic          cap_valid,
  output logic [SW-1:0] cap_sym
);
  logic busy;
  logic pat_data_ok, pat_eop_ok, rtz, take;

  always_comb begin
    pat_data_ok = !eop_req && in_valid(din);
    pat_eop_ok  = eop_req && (din == '0);
    rtz         = !eop_req && (din == '0);
    take        = !busy && slot_free && (pat_data_ok || pat_eop_ok);
    cap_valid   = take;
    cap_sym     = pat_eop_ok ? SW'(EOP_RANK) : SW'(in_rank(din));
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else if (take) busy <= 1'b1;
    else if (busy && rtz) busy <= 1'b0;
  end

  assign in_ack = busy;

  // R2 R3 R4: acknowledge only follows a legal flit or marker
  assert_accept_ok_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(pat_data_ok || pat_eop_ok));
  // R5: release only after return to zero
  assert_rtz_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> $past(rtz));
endmodule

// File: rtl/glx_ack_conv.sv
module glx_ack_conv (
  input  logic clk,
  input  logic rst,
  input  logic link_ack,
  output logic ack_evt
);
  logic ack_s, ack_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_s <= 1'b0;
      ack_p <= 1'b0;
    end else begin
      ack_s <= link_ack;
      ack_p <= ack_s;
    end
  end

  // either edge yields one event, independent of level (R9)
  assign ack_evt = ack_s ^ ack_p;
endmodule

// File: rtl/glx_nrz_out.sv
module glx_nrz_out
  import glx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_valid,
  input  logic [SW-1:0] cap_sym,
  input  logic          ack_evt,
  output logic          slot_free,
  output logic          awaiting,
  output logic          send,
  output logic [OW-1:0] wires
);
  logic          hv;
  logic [SW-1:0] hs;
  logic [OW-1:0] code_tab [SYMS];
  logic [OW-1:0] flip;

  for (genvar g = 0; g < SYMS; g++) begin : g_tab
    assign code_tab[g] = out_code(g);
  end

  always_comb begin
    send      = hv && !awaiting;
    slot_free = !hv;
    flip      = (int'(hs) < SYMS) ? code_tab[hs] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hv       <= 1'b0;
      hs       <= '0;
      awaiting <= 1'b0;
      wires    <= '0;
    end else begin
      if (send) begin
        wires    <= wires ^ flip;
        hv       <= 1'b0;
        awaiting <= 1'b1;
      end else if (awaiting && ack_evt) begin
        awaiting <= 1'b0;
      end
      if (cap_valid) begin
        hv <= 1'b1;
        hs <= cap_sym;
      end
    end
  end

  assert_two_wires_R6: assert property (@(posedge clk) disable iff (rst)
    (wires != $past(wires)) |-> ($countones(wires ^ $past(wires)) == OHOT));
  assert_wait_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (awaiting && !ack_evt) |=> $stable(wires));
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (awaiting && ack_evt) |=> !awaiting);
  assert_absorb_R10: assert property (@(posedge clk) disable iff (rst)
    (!awaiting && ack_evt && !send) |=> !awaiting);
  assert_hold_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (hv && !send) |=> (hv && $stable(hs)));
endmodule

// File: rtl/glx_link_tx.sv
module glx_link_tx
  import glx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] in_data,
  input  logic          in_eop,
  output logic          in_ack,
  output logic [OW-1:0] link_out,
  input  logic          link_ack
);
  logic          slot_free, cap_valid, ack_evt, awaiting, send;
  logic [SW-1:0] cap_sym;

  glx_fourph_in u_in (
    .clk(clk), .rst(rst), .din(in_data), .eop_req(in_eop),
    .slot_free(slot_free), .in_ack(in_ack),
    .cap_valid(cap_valid), .cap_sym(cap_sym)
  );

  glx_ack_conv u_ack (
    .clk(clk), .rst(rst), .link_ack(link_ack), .ack_evt(ack_evt)
  );

  glx_nrz_out u_out (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_sym(cap_sym),
    .ack_evt(ack_evt), .slot_free(slot_free), .awaiting(awaiting),
    .send(send), .wires(link_out)
  );
endmodule

// File: tb/glx_link_tx_tb_top.sv
`timescale 1ns/1ps
module glx_link_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] in_data = '0;
  logic       in_eop = 1'b0;
  logic       in_ack;
  logic [6:0] link_out;
  logic       link_ack = 1'b0;

  int total = 0;
  int bad = 0;
  logic [6:0] tx_code [17];
  logic [5:0] in_pat [16];
  logic [6:0] exp_log [128];
  logic [6:0] rx_log [128];
  int exp_n = 0, rx_n = 0, cmp_i = 0;
  bit auto_ack = 1'b1;
  bit manual_req = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  glx_link_tx dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_eop(in_eop),
    .in_ack(in_ack), .link_out(link_out), .link_ack(link_ack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // far-end model: records transitions, returns acknowledge flips
  initial begin
    logic [6:0] last_w;
    int ack_cnt;
    last_w = '0;
    ack_cnt = -1;
    forever begin
      @(negedge clk);
      if (!rst && link_out != last_w) begin
        chk($countones(link_out ^ last_w) == 2, "R6", "wires flipped",
            $countones(link_out ^ last_w), 2);
        rx_log[rx_n] = link_out ^ last_w;
        rx_n++;
        last_w = link_out;
        if (auto_ack) ack_cnt = 3;
      end
      if (manual_req) begin
        link_ack = ~link_ack;
        manual_req = 1'b0;
      end else if (ack_cnt > 0) begin
        ack_cnt--;
      end else if (ack_cnt == 0) begin
        link_ack = ~link_ack;
        ack_cnt = -1;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_sym(input int s);
    int t;
    @(negedge clk);
    if (s == 16) begin in_eop = 1'b1; in_data = '0; end
    else begin in_eop = 1'b0; in_data = in_pat[s]; end
    exp_log[exp_n] = tx_code[s];
    exp_n++;
    t = 0;
    while (!in_ack && t < 300) begin @(negedge clk); t++; end
    chk(in_ack == 1'b1, (s == 16) ? "R4" : "R2", "acknowledge raised", in_ack, 1);
    in_eop = 1'b0;
    in_data = '0;
    t = 0;
    while (in_ack && t < 50) begin @(negedge clk); t++; end
    chk(in_ack == 1'b0, "R5", "acknowledge released", in_ack, 0);
  endtask

  task automatic drain_cmp(input string req);
    int t;
    t = 0;
    while (rx_n < exp_n && t < 600) begin @(negedge clk); t++; end
    wait_cyc(10);
    chk(rx_n == exp_n, "R7", "symbol count", rx_n, exp_n);
    for (int i = cmp_i; i < exp_n; i++)
      chk(rx_log[i] == exp_log[i], req, $sformatf("symbol %0d code", i),
          rx_log[i], exp_log[i]);
    cmp_i = exp_n;
  endtask

  initial begin
    int n, rx0;
    // link codes by ordered wire pairs, input codes by ordered triples
    n = 0;
    for (int hi = 1; hi < 7; hi++)
      for (int lo = 0; lo < hi; lo++) begin
        if (n < 17) tx_code[n] = 7'((1 << hi) | (1 << lo));
        n++;
      end
    n = 0;
    for (int a = 2; a < 6; a++)
      for (int b = 1; b < a; b++)
        for (int c = 0; c < b; c++) begin
          if (n < 16) in_pat[n] = 6'((1 << a) | (1 << b) | (1 << c));
          n++;
        end

    wait_cyc(6);
    chk(in_ack == 1'b0, "R1", "in_ack under reset", in_ack, 0);
    chk(link_out == 7'd0, "R1", "link under reset", link_out, 0);
    @(negedge clk); rst = 1'b0;
    wait_cyc(2);
    chk(in_ack == 1'b0 && link_out == 7'd0, "R1", "state after reset", link_out, 0);

    // stray acknowledge right after reset must be absorbed
    manual_req = 1'b1;
    wait_cyc(10);
    chk(link_out == 7'd0, "R10", "link quiet after stray ack", link_out, 0);

    // ascending packet with all flits, then marker
    for (int s = 0; s < 17; s++) send_sym(s);
    drain_cmp("R6");
    // descending packet
    for (int s = 15; s >= 0; s--) send_sym(s);
    send_sym(16);
    drain_cmp("R7");
    // marker-only packet and a short one
    send_sym(16); send_sym(5); send_sym(16);
    drain_cmp("R4");

    // hold-high check: ack stays up while inputs stay driven
    @(negedge clk); in_data = in_pat[9];
    exp_log[exp_n] = tx_code[9]; exp_n++;
    wait_cyc(12);
    chk(in_ack == 1'b1, "R5", "ack held with data present", in_ack, 1);
    in_data = '0;
    wait_cyc(4);
    chk(in_ack == 1'b0, "R5", "ack falls after zero", in_ack, 0);
    drain_cmp("R6");

    // sweep every input pattern that is not a legal flit
    for (int p = 0; p < 64; p++) begin
      if (!($countones(p[5:0]) == 3 && p < 49)) begin
        rx0 = rx_n;
        @(negedge clk); in_data = p[5:0];
        wait_cyc(6);
        chk(in_ack == 1'b0 && rx_n == rx0, "R3",
            $sformatf("pattern %0d ignored", p), in_ack, 0);
        in_data = '0;
        wait_cyc(2);
      end
    end
    rx0 = rx_n;
    @(negedge clk); in_data = in_pat[0]; in_eop = 1'b1;
    wait_cyc(6);
    chk(in_ack == 1'b0 && rx_n == rx0, "R3", "marker with data ignored", in_ack, 0);
    in_data = '0; in_eop = 1'b0;
    wait_cyc(3);

    // withheld acknowledge: one in flight, one held, third held off
    auto_ack = 1'b0;
    rx0 = rx_n;
    send_sym(3);
    send_sym(7);
    wait_cyc(20);
    chk(rx_n == rx0 + 1, "R8", "only one symbol without ack", rx_n, rx0 + 1);
    @(negedge clk); in_data = in_pat[11];
    wait_cyc(20);
    chk(in_ack == 1'b0, "R11", "third flit held off", in_ack, 0);
    chk(rx_n == rx0 + 1, "R8", "link still waiting", rx_n, rx0 + 1);
    exp_log[exp_n] = tx_code[11]; exp_n++;
    auto_ack = 1'b1;
    manual_req = 1'b1;
    n = 0;
    while (!in_ack && n < 300) begin @(negedge clk); n++; end
    chk(in_ack == 1'b1, "R11", "third flit taken after ack", in_ack, 1);
    in_data = '0;
    wait_cyc(3);
    drain_cmp("R7");

    // stray flip between packets gives no credit (falling or rising)
    auto_ack = 1'b0;
    manual_req = 1'b1;
    wait_cyc(10);
    rx0 = rx_n;
    send_sym(2);
    send_sym(4);
    wait_cyc(20);
    chk(rx_n == rx0 + 1, "R10", "stray flip not credited", rx_n, rx0 + 1);
    auto_ack = 1'b1;
    manual_req = 1'b1;
    drain_cmp("R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule